// File: doc/BRIEF.md
# Serial Buffer Status Flag Controller

This block keeps the three status flags of a double-buffered serial port: "transmit holding register empty", "receive holding register full" and "receive overrun". It watches CPU accesses to the status register, DMA accesses to the two data registers, the transmitter and receiver enables, a standby request, and strobes from the transmit and receive shifters. From these it updates the flags. It also produces the enable that copies a finished frame into the receive holding register.

A flag can be cleared by software only through a handshake. Software must first read the status register while that flag is 1, which arms that flag. A later write with a 0 in the flag's bit position then clears it. Writing 1, or writing 0 to a flag that is not armed, does nothing. A DMA access to the matching data register also clears the transmit or receive flag directly. When a frame arrives with an error, or while the receiver is disabled, the receive holding register and its flag are left as they are. When a frame arrives while the buffer is still full, the new frame is dropped and the overrun flag is raised.

Top module: `sbf_status_ctrl`

## Requirements
- R1: After reset `stat_o` reads 0x80: the transmit-empty flag (bit 7) is 1, the receive-full flag (bit 6) and the overrun flag (bit 5) are 0, and bits 4..0 always read 0. `rdr_load_o` is 0 while no frame completes.
- R2: Bit 7 reads 1 in the cycle after any cycle with `standby_i`=1, `tx_en_i`=0 or `tsr_load_i`=1.
- R3: A status write with bit 7 = 0 clears bit 7 only if a status read returned bit 7 = 1 since the flag last became 1 and since the last such clearing write. A write with bit 7 = 1, or a write of 0 without that read, leaves bit 7 unchanged.
- R4: `dma_tdr_wr_i` clears bit 7 one cycle later. Any bit-7 set condition of R2 in the same cycle wins, and bit 7 stays 1.
- R5: A frame is good when `rx_done_i`=1, `rx_err_i`=0, `rx_en_i`=1 and `standby_i`=0. A good frame while bit 6 is 0 drives `rdr_load_o`=1 in that same cycle, and bit 6 reads 1 in the next cycle.
- R6: A frame with `rx_err_i`=1, or one completing while `rx_en_i`=0, gives `rdr_load_o`=0 and leaves bits 6 and 5 unchanged.
- R7: Bit 6 is cleared one cycle after a `dma_rdr_rd_i` strobe, after an armed write of 0 (the same handshake as in R3, applied to bit 6), or after a cycle with `standby_i`=1. Standby also blocks `rdr_load_o`.
- R8: A good frame while bit 6 is 1 keeps `rdr_load_o`=0 and sets bit 5 in the next cycle. Bit 5 is cleared only by its own armed write of 0. DMA reads and standby do not clear it.
- R9: Each flag has its own arm. An armed write clears only the flags written as 0. A flag that has been cleared needs a fresh read as 1 before a later write of 0 can clear it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| stat_rd_i | input | 1 | CPU status register read strobe |
| stat_wr_i | input | 1 | CPU status register write strobe |
| stat_wdata_i | input | 8 | CPU status write data |
| dma_tdr_wr_i | input | 1 | DMA write to transmit data register |
| dma_rdr_rd_i | input | 1 | DMA read of receive data register |
| tx_en_i | input | 1 | Transmitter enable |
| rx_en_i | input | 1 | Receiver enable |
| standby_i | input | 1 | Standby request |
| tsr_load_i | input | 1 | Transmit shift register loaded from holding register |
| rx_done_i | input | 1 | Receive frame complete strobe |
| rx_err_i | input | 1 | Error on the completing frame |
| stat_o | output | 8 | Status register value (bits 7, 6, 5 are flags) |
| rdr_load_o | output | 1 | Capture enable for the receive holding register |

## Verification
`rdr_load_o` is combinational, so it is due in the cycle the frame strobe is driven. The bench samples it 1 ns after driving the inputs on the falling edge. All three flags are registered, so their response is due after the next rising edge. The bench reads `stat_o` on the following falling edge, before the next vector is applied. Reset is asynchronous, so its value is checked 1 ns after `rst_n` falls, with no clock edge in between.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int NFLAG   = 3;
  localparam int TOP_BIT = 7;
  localparam int IDX_TXE = 0;
  localparam int IDX_RXF = 1;
  localparam int IDX_OVR = 2;

  // flag index -> status bit position (7, 6, 5)
  function automatic int flag_pos(int idx);
    return TOP_BIT - idx;
  endfunction

  // only the transmit-empty flag comes out of reset as 1
  function automatic logic flag_rst(int idx);
    return (idx == IDX_TXE);
  endfunction
endpackage

// File: rtl/sbf_event_dec.sv
module sbf_event_dec (
  input  logic tx_en_i,
  input  logic rx_en_i,
  input  logic standby_i,
  input  logic tsr_load_i,
  input  logic dma_tdr_wr_i,
  input  logic dma_rdr_rd_i,
  input  logic rx_done_i,
  input  logic rx_err_i,
  input  logic rxf_q_i,
  output logic txe_set_o,
  output logic txe_clr_o,
  output logic rxf_set_o,
  output logic rxf_clr_o,
  output logic rxf_force_o,
  output logic ovr_set_o,
  output logic rdr_load_o
);
  logic good_frame;

  always_comb begin
    good_frame  = rx_done_i & ~rx_err_i & rx_en_i & ~standby_i;
    rdr_load_o  = good_frame & ~rxf_q_i;
    ovr_set_o   = good_frame & rxf_q_i;
    txe_set_o   = standby_i | ~tx_en_i | tsr_load_i;
    txe_clr_o   = dma_tdr_wr_i;
    rxf_set_o   = good_frame & ~rxf_q_i;
    rxf_clr_o   = dma_rdr_rd_i;
    rxf_force_o = standby_i;
  end
endmodule

// File: rtl/sbf_flag_cell.sv
module sbf_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic force_clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic hs_clr;
  logic upd_en;

  always_comb begin
    hs_clr = wr_i & ~wbit_i & arm_q;
    if (force_clr_i)          flag_d = 1'b0;
    else if (set_i)           flag_d = 1'b1;
    else if (hs_clr || clr_i) flag_d = 1'b0;
    else                      flag_d = flag_q;
    arm_d  = flag_d & ~hs_clr & (arm_q | (rd_i & flag_q));
    upd_en = (flag_d != flag_q) | (arm_d != arm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else if (upd_en) begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sbf_status_ctrl.sv
module sbf_status_ctrl
  import sbf_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  input  logic              dma_tdr_wr_i,
  input  logic              dma_rdr_rd_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              standby_i,
  input  logic              tsr_load_i,
  input  logic              rx_done_i,
  input  logic              rx_err_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              rdr_load_o
);
  logic [NFLAG-1:0] set_v, clr_v, force_v, flag_v;
  logic             unused_wdata;

  sbf_event_dec u_dec (
    .tx_en_i     (tx_en_i),
    .rx_en_i     (rx_en_i),
    .standby_i   (standby_i),
    .tsr_load_i  (tsr_load_i),
    .dma_tdr_wr_i(dma_tdr_wr_i),
    .dma_rdr_rd_i(dma_rdr_rd_i),
    .rx_done_i   (rx_done_i),
    .rx_err_i    (rx_err_i),
    .rxf_q_i     (flag_v[IDX_RXF]),
    .txe_set_o   (set_v[IDX_TXE]),
    .txe_clr_o   (clr_v[IDX_TXE]),
    .rxf_set_o   (set_v[IDX_RXF]),
    .rxf_clr_o   (clr_v[IDX_RXF]),
    .rxf_force_o (force_v[IDX_RXF]),
    .ovr_set_o   (set_v[IDX_OVR]),
    .rdr_load_o  (rdr_load_o)
  );

  assign force_v[IDX_TXE] = 1'b0;
  assign force_v[IDX_OVR] = 1'b0;
  assign clr_v[IDX_OVR]   = 1'b0;

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      localparam int P = flag_pos(i);
      sbf_flag_cell #(.RST_VAL(flag_rst(i))) u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (stat_rd_i),
        .wr_i       (stat_wr_i),
        .wbit_i     (stat_wdata_i[P]),
        .set_i      (set_v[i]),
        .clr_i      (clr_v[i]),
        .force_clr_i(force_v[i]),
        .flag_o     (flag_v[i])
      );
    end
  endgenerate

  always_comb begin
    stat_o = '0;
    for (int i = 0; i < NFLAG; i++) stat_o[flag_pos(i)] = flag_v[i];
  end

  assign unused_wdata = ^stat_wdata_i;
endmodule

// File: rtl/sbf_status_chk.sv
module sbf_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_wr_i,
  input logic       dma_tdr_wr_i,
  input logic       tx_en_i,
  input logic       rx_en_i,
  input logic       standby_i,
  input logic       tsr_load_i,
  input logic       rx_done_i,
  input logic       rx_err_i,
  input logic [7:0] stat_o,
  input logic       rdr_load_o
);
  always_comb begin
    if (rst_n) assert_unused_zero_R1: assert (stat_o[4:0] == 5'b0);
  end

  assert_txe_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_i || !tx_en_i || tsr_load_i) |=> stat_o[7]);

  assert_txe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr_i && !dma_tdr_wr_i && !tsr_load_i && tx_en_i && !standby_i) |=> $stable(stat_o[7]));

  assert_txe_dma_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tdr_wr_i && !tsr_load_i && tx_en_i && !standby_i) |=> !stat_o[7]);

  assert_rxf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rdr_load_o |=> stat_o[6]);

  assert_load_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdr_load_o |-> (rx_done_i && !rx_err_i && rx_en_i && !standby_i && !stat_o[6]));

  assert_rxf_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> !stat_o[6]);

  assert_ovr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && !rx_err_i && rx_en_i && !standby_i && stat_o[6]) |=> stat_o[5]);

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[5] && !stat_wr_i) |=> stat_o[5]);
endmodule

bind sbf_status_ctrl sbf_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stat_wr_i   (stat_wr_i),
  .dma_tdr_wr_i(dma_tdr_wr_i),
  .tx_en_i     (tx_en_i),
  .rx_en_i     (rx_en_i),
  .standby_i   (standby_i),
  .tsr_load_i  (tsr_load_i),
  .rx_done_i   (rx_done_i),
  .rx_err_i    (rx_err_i),
  .stat_o      (stat_o),
  .rdr_load_o  (rdr_load_o)
);

// File: tb/sbf_status_ctrl_test.sv
module sbf_status_ctrl_test;
  typedef struct packed {
    logic       rd;
    logic       wr;
    logic [7:0] wd;
    logic       dw;
    logic       dr;
    logic       te;
    logic       re;
    logic       sb;
    logic       tl;
    logic       rxd;
    logic       rxe;
    logic [7:0] es;
    logic       el;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    // rd wr wd    dw dr te re sb tl rxd rxe exp   load req
    '{0, 0, 8'h00, 0, 0, 1, 1, 0, 0, 0, 0, 8'h80, 0, 1},  // R1 idle
    '{0, 1, 8'h00, 0, 0, 1, 1, 0, 0, 0, 0, 8'h80, 0, 3},  // R3 write 0 unarmed
    '{1, 0, 8'h00, 0, 0, 1, 1, 0, 0, 0, 0, 8'h80, 0, 3},  // R3 arm TXE
    '{0, 1, 8'hFF, 0, 0, 1, 1, 0, 0, 0, 0, 8'h80, 0, 3},  // R3 write 1 ignored
    '{0, 1, 8'h00, 0, 0, 1, 1, 0, 0, 0, 0, 8'h00, 0, 3},  // R3 armed clear
    '{0, 0, 8'h00, 0, 0, 1, 1, 0, 1, 0, 0, 8'h80, 0, 2},  // R2 shift load
    '{0, 0, 8'h00, 1, 0, 1, 1, 0, 0, 0, 0, 8'h00, 0, 4},  // R4 dma write
    '{0, 0, 8'h00, 1, 0, 1, 1, 0, 1, 0, 0, 8'h80, 0, 4},  // R4 set wins
    '{0, 0, 8'h00, 1, 0, 1, 1, 0, 0, 0, 0, 8'h00, 0, 4},  // R4
    '{0, 0, 8'h00, 0, 0, 0, 1, 0, 0, 0, 0, 8'h80, 0, 2},  // R2 tx disabled
    '{0, 0, 8'h00, 1, 0, 1, 1, 0, 0, 0, 0, 8'h00, 0, 4},  // R4
    '{0, 0, 8'h00, 0, 0, 1, 1, 1, 0, 0, 0, 8'h80, 0, 2},  // R2 standby
    '{0, 0, 8'h00, 0, 0, 1, 1, 0, 0, 1, 0, 8'hC0, 1, 5},  // R5 good frame
    '{0, 0, 8'h00, 0, 0, 1, 1, 0, 0, 1, 1, 8'hC0, 0, 6},  // R6 error frame
    '{0, 0, 8'h00, 0, 0, 1, 1, 0, 0, 1, 0, 8'hE0, 0, 8},  // R8 overrun
    '{0, 0, 8'h00, 0, 1, 1, 1, 0, 0, 0, 0, 8'hA0, 0, 7},  // R7 dma read, R8 stays
    '{0, 0, 8'h00, 0, 0, 1, 0, 0, 0, 1, 0, 8'hA0, 0, 6},  // R6 rx disabled
    '{0, 0, 8'h00, 0, 0, 1, 1, 0, 0, 1, 1, 8'hA0, 0, 6},  // R6 error, empty buf
    '{0, 0, 8'h00, 0, 0, 1, 1, 0, 0, 1, 0, 8'hE0, 1, 5},  // R5
    '{1, 0, 8'h00, 0, 0, 1, 1, 0, 0, 0, 0, 8'hE0, 0, 9},  // R9 arm all
    '{0, 1, 8'hA0, 0, 0, 1, 1, 0, 0, 0, 0, 8'hA0, 0, 7},  // R7 clear only bit 6
    '{0, 1, 8'h00, 0, 0, 1, 1, 0, 0, 0, 0, 8'h00, 0, 8},  // R8 ovr handshake
    '{0, 0, 8'h00, 0, 0, 1, 1, 0, 0, 1, 0, 8'h40, 1, 5},  // R5
    '{0, 1, 8'h00, 0, 0, 1, 1, 0, 0, 0, 0, 8'h40, 0, 9},  // R9 needs fresh read
    '{0, 0, 8'h00, 0, 0, 1, 1, 1, 0, 0, 0, 8'h80, 0, 7},  // R7 standby clears
    '{0, 0, 8'h00, 0, 0, 1, 1, 1, 0, 1, 0, 8'h80, 0, 7},  // R7 standby blocks load
    '{0, 0, 8'h00, 0, 0, 1, 1, 0, 0, 1, 0, 8'hC0, 1, 5},  // R5
    '{1, 0, 8'h00, 0, 0, 1, 1, 0, 0, 0, 0, 8'hC0, 0, 9},  // R9 arm
    '{0, 0, 8'h00, 0, 1, 1, 1, 0, 0, 0, 0, 8'h80, 0, 7},  // R7 dma read
    '{0, 1, 8'h00, 0, 0, 1, 1, 0, 0, 0, 0, 8'h00, 0, 9}   // R9 bit 6 arm gone
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stat_rd_i, stat_wr_i, dma_tdr_wr_i, dma_rdr_rd_i;
  logic       tx_en_i, rx_en_i, standby_i, tsr_load_i, rx_done_i, rx_err_i;
  logic [7:0] stat_wdata_i;
  logic [7:0] stat_o;
  logic       rdr_load_o;
  int         n_chk = 0;
  int         n_fail = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  sbf_status_ctrl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .stat_rd_i   (stat_rd_i),
    .stat_wr_i   (stat_wr_i),
    .stat_wdata_i(stat_wdata_i),
    .dma_tdr_wr_i(dma_tdr_wr_i),
    .dma_rdr_rd_i(dma_rdr_rd_i),
    .tx_en_i     (tx_en_i),
    .rx_en_i     (rx_en_i),
    .standby_i   (standby_i),
    .tsr_load_i  (tsr_load_i),
    .rx_done_i   (rx_done_i),
    .rx_err_i    (rx_err_i),
    .stat_o      (stat_o),
    .rdr_load_o  (rdr_load_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    stat_rd_i = 0; stat_wr_i = 0; stat_wdata_i = 8'h00;
    dma_tdr_wr_i = 0; dma_rdr_rd_i = 0; tx_en_i = 1; rx_en_i = 1;
    standby_i = 0; tsr_load_i = 0; rx_done_i = 0; rx_err_i = 0;
  endtask

  initial begin
    #40000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset status", stat_o, 8'h80);
    check("R1 reset load", {7'b0, rdr_load_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      stat_rd_i = TBL[i].rd;  stat_wr_i = TBL[i].wr;  stat_wdata_i = TBL[i].wd;
      dma_tdr_wr_i = TBL[i].dw; dma_rdr_rd_i = TBL[i].dr;
      tx_en_i = TBL[i].te; rx_en_i = TBL[i].re; standby_i = TBL[i].sb;
      tsr_load_i = TBL[i].tl; rx_done_i = TBL[i].rxd; rx_err_i = TBL[i].rxe;
      #1;
      check($sformatf("R%0d vec %0d load", TBL[i].req, i), {7'b0, rdr_load_o}, {7'b0, TBL[i].el});
      @(negedge clk);
      idle();
      check($sformatf("R%0d vec %0d status", TBL[i].req, i), stat_o, TBL[i].es);
    end

    // R1: asynchronous reset from a non-reset state
    rx_done_i = 1;
    @(negedge clk);
    idle();
    dma_tdr_wr_i = 1;
    @(negedge clk);
    idle();
    check("R1 pre-reset state", stat_o, 8'h40);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", stat_o, 8'h80);
    @(negedge clk);
    rst_n = 1'b1;
    // R3: arms do not survive reset
    stat_wr_i = 1;
    @(negedge clk);
    idle();
    check("R3 write after reset unarmed", stat_o, 8'h80);
    // R3: read while flag is 0 does not arm
    dma_tdr_wr_i = 1;
    @(negedge clk);
    idle();
    stat_rd_i = 1;
    @(negedge clk);
    idle();
    tsr_load_i = 1;
    @(negedge clk);
    idle();
    stat_wr_i = 1;
    @(negedge clk);
    idle();
    check("R3 read-as-0 gives no arm", stat_o, 8'h80);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule